// File: doc/BRIEF.md
# Program Counter with Paged Upper Latch

This block holds the fetch address of a small core whose instructions are 14 bits wide. The address is 13 bits, so it reaches 8192 program words. It steps the address forward once for each fetch. It can also send the address to a fixed interrupt entry, take a return address from an external stack, or form a jump or call target from an 11-bit literal field.

The low byte of the address is visible on a register-file port as an ordinary read/write location. A second location on the same port holds a 5-bit upper latch. Software loads the latch first. It then writes the low byte, and that write moves the whole latch into address bits 12:8. A jump or call uses only the top two latch bits, which select a 2K page. The latch keeps its value across stack pushes and pops.

The core's decoder drives one-cycle strobes for each kind of event. When a call or interrupt is taken, the stack captures `push_addr`.

Top module: `pc_unit`

## Requirements
- R1: While reset is asserted, `fetch_addr` is 0000h, and the upper latch reads back as zero afterwards.
- R2: With only `advance` high, `fetch_addr` increases by one on the next clock and wraps from 1FFFh to 0000h.
- R3: With no strobe and no low-byte write, `fetch_addr` holds its value.
- R4: `irq_take` loads 0004h on the next clock, whatever else is requested in the same cycle.
- R5: `jump_go` loads `{latch[4:3], jump_tgt[10:0]}`.
- R6: A register-file write to offset 02h loads `{latch[4:0], rf_wdata[7:0]}` into the address.
- R7: A register-file write to offset 0Ah stores `rf_wdata[4:0]` in the latch and leaves `fetch_addr` unchanged. Reading offset 0Ah returns `{3'b000, latch}`.
- R8: Reading offset 02h returns `fetch_addr[7:0]`.
- R9: `ret_go` loads `stack_addr`, and the latch is left unchanged.
- R10: `push_addr` always equals `fetch_addr + 1` modulo 2000h.
- R11: When several requests arrive in the same cycle, they are served in this order: interrupt, return, jump, low-byte write, advance.
- R12: A write to any other register-file offset has no effect on the address or the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Sequential step strobe |
| irq_take | input | 1 | Interrupt taken strobe |
| ret_go | input | 1 | Return strobe |
| jump_go | input | 1 | Jump or call strobe |
| jump_tgt | input | 11 | Literal target field |
| stack_addr | input | 13 | Address popped from the stack |
| rf_wr_en | input | 1 | Register-file write enable |
| rf_addr | input | 7 | Register-file offset |
| rf_wdata | input | 8 | Register-file write data |
| rf_rdata | output | 8 | Register-file read data |
| fetch_addr | output | 13 | Current fetch address |
| push_addr | output | 13 | Return address for the stack |

## Verification
A wrong upper latch stays hidden until the next low-byte write or jump. At that point it appears as a wrong page in `fetch_addr` one clock later, so the bench reads the latch back directly as well. A fault in priority or in the increment shows on `fetch_addr` at the very next edge. A fault in the return-address adder shows on `push_addr` in the same cycle. The bench also follows a return with a latch read, which exposes a latch that the stack disturbed.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
   typedef enum logic [2:0] {
      SRC_HOLD = 3'd0,
      SRC_INC  = 3'd1,
      SRC_IRQ  = 3'd2,
      SRC_RET  = 3'd3,
      SRC_JMP  = 3'd4,
      SRC_LOW  = 3'd5
   } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
   import pc_unit_pkg::*;
(
   input  logic    irq_take,
   input  logic    ret_go,
   input  logic    jump_go,
   input  logic    low_wr,
   input  logic    advance,
   output pc_src_e src
);
   always_comb begin
      if (irq_take)     src = SRC_IRQ;
      else if (ret_go)  src = SRC_RET;
      else if (jump_go) src = SRC_JMP;
      else if (low_wr)  src = SRC_LOW;
      else if (advance) src = SRC_INC;
      else              src = SRC_HOLD;
   end
endmodule

// File: rtl/pc_latch_reg.sv
module pc_latch_reg #(
   parameter int LAT_W  = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [LAT_W-1:0]  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata[LAT_W-1:0];
   end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
   import pc_unit_pkg::*;
#(
   parameter int          PC_W       = 13,
   parameter int          LAT_W      = 5,
   parameter int          LIT_W      = 11,
   parameter int          DATA_W     = 8,
   parameter bit          JUMP_PAGED = 1'b1,
   parameter logic [12:0] IRQ_VEC    = 13'h0004
) (
   input  pc_src_e           src,
   input  logic [PC_W-1:0]   pc,
   input  logic [LAT_W-1:0]  latch,
   input  logic [LIT_W-1:0]  tgt,
   input  logic [PC_W-1:0]   stack_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PC_W-1:0]   nxt,
   output logic [PC_W-1:0]   inc
);
   localparam int JHI_W = PC_W - LIT_W;
   localparam int HI_W  = PC_W - DATA_W;

   logic [PC_W-1:0] jmp_addr;
   logic [PC_W-1:0] low_addr;

   assign inc      = pc + {{(PC_W-1){1'b0}}, 1'b1};
   assign low_addr = {latch[HI_W-1:0], wdata};

   generate
      if (JUMP_PAGED) begin : g_paged
         assign jmp_addr = {latch[LAT_W-1 -: JHI_W], tgt};
      end else begin : g_local
         assign jmp_addr = {pc[PC_W-1 -: JHI_W], tgt};
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_IRQ:  nxt = IRQ_VEC[PC_W-1:0];
         SRC_RET:  nxt = stack_addr;
         SRC_JMP:  nxt = jmp_addr;
         SRC_LOW:  nxt = low_addr;
         SRC_INC:  nxt = inc;
         default:  nxt = pc;
      endcase
   end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
   import pc_unit_pkg::*;
#(
   parameter int          PC_W       = 13,
   parameter int          LAT_W      = 5,
   parameter int          LIT_W      = 11,
   parameter int          DATA_W     = 8,
   parameter int          ADDR_W     = 7,
   parameter logic [6:0]  LOW_OFS    = 7'h02,
   parameter logic [6:0]  LATCH_OFS  = 7'h0A,
   parameter logic [12:0] IRQ_VEC    = 13'h0004,
   parameter bit          JUMP_PAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              irq_take,
   input  logic              ret_go,
   input  logic              jump_go,
   input  logic [LIT_W-1:0]  jump_tgt,
   input  logic [PC_W-1:0]   stack_addr,
   input  logic              rf_wr_en,
   input  logic [ADDR_W-1:0] rf_addr,
   input  logic [DATA_W-1:0] rf_wdata,
   output logic [DATA_W-1:0] rf_rdata,
   output logic [PC_W-1:0]   fetch_addr,
   output logic [PC_W-1:0]   push_addr
);
   localparam int HI_W  = PC_W - DATA_W;
   localparam int PAD_W = DATA_W - LAT_W;

   if (LAT_W != HI_W) begin : g_chk_lat
      $error("pc_unit: latch width must equal PC_W - DATA_W");
   end
   if (LIT_W >= PC_W) begin : g_chk_lit
      $error("pc_unit: literal field must be narrower than PC");
   end
   if (PAD_W <= 0) begin : g_chk_pad
      $error("pc_unit: latch must be narrower than a data word");
   end
   if (ADDR_W > 7) begin : g_chk_addr
      $error("pc_unit: offset width above 7 is not supported");
   end

   logic             low_wr;
   logic             lat_wr;
   logic [LAT_W-1:0] latch;
   logic [PC_W-1:0]  pc;
   logic [PC_W-1:0]  pc_nxt;
   logic [PC_W-1:0]  pc_inc;
   pc_src_e          src;

   assign low_wr = rf_wr_en && (rf_addr == LOW_OFS[ADDR_W-1:0]);
   assign lat_wr = rf_wr_en && (rf_addr == LATCH_OFS[ADDR_W-1:0]);

   pc_src_arb u_arb (
      .irq_take (irq_take),
      .ret_go   (ret_go),
      .jump_go  (jump_go),
      .low_wr   (low_wr),
      .advance  (advance),
      .src      (src)
   );

   pc_latch_reg #(.LAT_W(LAT_W), .DATA_W(DATA_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lat_wr),
      .wdata (rf_wdata),
      .q     (latch)
   );

   pc_next_calc #(
      .PC_W(PC_W), .LAT_W(LAT_W), .LIT_W(LIT_W), .DATA_W(DATA_W),
      .JUMP_PAGED(JUMP_PAGED), .IRQ_VEC(IRQ_VEC)
   ) u_next (
      .src        (src),
      .pc         (pc),
      .latch      (latch),
      .tgt        (jump_tgt),
      .stack_addr (stack_addr),
      .wdata      (rf_wdata),
      .nxt        (pc_nxt),
      .inc        (pc_inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_nxt;
   end

   always_comb begin
      if (rf_addr == LOW_OFS[ADDR_W-1:0])
         rf_rdata = pc[DATA_W-1:0];
      else if (rf_addr == LATCH_OFS[ADDR_W-1:0])
         rf_rdata = {{PAD_W{1'b0}}, latch};
      else
         rf_rdata = '0;
   end

   assign fetch_addr = pc;
   assign push_addr  = pc_inc;
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
   parameter int          PC_W    = 13,
   parameter int          LIT_W   = 11,
   parameter int          DATA_W  = 8,
   parameter int          ADDR_W  = 7,
   parameter logic [6:0]  LOW_OFS = 7'h02,
   parameter logic [12:0] IRQ_VEC = 13'h0004
) (
   input logic              clk,
   input logic              rst_n,
   input logic              advance,
   input logic              irq_take,
   input logic              ret_go,
   input logic              jump_go,
   input logic [LIT_W-1:0]  jump_tgt,
   input logic [PC_W-1:0]   stack_addr,
   input logic              rf_wr_en,
   input logic [ADDR_W-1:0] rf_addr,
   input logic [DATA_W-1:0] rf_wdata,
   input logic [PC_W-1:0]   fetch_addr,
   input logic [PC_W-1:0]   push_addr
);
   logic low_hit;
   assign low_hit = rf_wr_en && (rf_addr == LOW_OFS[ADDR_W-1:0]);

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_ZERO: assert (fetch_addr == '0); // R1
   end

   AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> fetch_addr == IRQ_VEC[PC_W-1:0]); // R4
   AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && !irq_take) |=> fetch_addr == $past(stack_addr)); // R9
   AST_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_go && !ret_go && !irq_take) |=> fetch_addr[LIT_W-1:0] == $past(jump_tgt)); // R5
   AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (low_hit && !jump_go && !ret_go && !irq_take) |=> fetch_addr[DATA_W-1:0] == $past(rf_wdata)); // R6
   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !low_hit && !jump_go && !ret_go && !irq_take)
      |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R2
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !low_hit && !jump_go && !ret_go && !irq_take) |=> $stable(fetch_addr)); // R3
   AST_PUSH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      push_addr == PC_W'(fetch_addr + 1'b1)); // R10
endmodule

bind pc_unit pc_unit_chk #(
   .PC_W(PC_W), .LIT_W(LIT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .LOW_OFS(LOW_OFS), .IRQ_VEC(IRQ_VEC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .advance(advance), .irq_take(irq_take),
   .ret_go(ret_go), .jump_go(jump_go), .jump_tgt(jump_tgt),
   .stack_addr(stack_addr), .rf_wr_en(rf_wr_en), .rf_addr(rf_addr),
   .rf_wdata(rf_wdata), .fetch_addr(fetch_addr), .push_addr(push_addr)
);

// File: tb/pc_unit_test.sv
module pc_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        advance = 1'b0, irq_take = 1'b0, ret_go = 1'b0, jump_go = 1'b0;
   logic [10:0] jump_tgt = '0;
   logic [12:0] stack_addr = '0;
   logic        rf_wr_en = 1'b0;
   logic [6:0]  rf_addr = '0;
   logic [7:0]  rf_wdata = '0;
   logic [7:0]  rf_rdata;
   logic [12:0] fetch_addr, push_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pc_unit uut (
      .clk(clk), .rst_n(rst_n), .advance(advance), .irq_take(irq_take),
      .ret_go(ret_go), .jump_go(jump_go), .jump_tgt(jump_tgt),
      .stack_addr(stack_addr), .rf_wr_en(rf_wr_en), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .fetch_addr(fetch_addr),
      .push_addr(push_addr)
   );

   // ops: 0 idle, 1 advance, 2 irq, 3 return, 4 jump, 5 low write, 6 latch write, 7 other write
   localparam int NV = 16;
   localparam logic [28:0] VEC [NV] = '{
      {3'd1, 13'h0000, 13'h0001},   // R2
      {3'd1, 13'h0000, 13'h0002},   // R2
      {3'd6, 13'h001B, 13'h0002},   // R7
      {3'd5, 13'h0034, 13'h1B34},   // R6
      {3'd1, 13'h0000, 13'h1B35},   // R2
      {3'd4, 13'h0123, 13'h1923},   // R5
      {3'd0, 13'h0000, 13'h1923},   // R3
      {3'd3, 13'h0ABC, 13'h0ABC},   // R9
      {3'd2, 13'h0000, 13'h0004},   // R4
      {3'd7, 13'h0055, 13'h0004},   // R12
      {3'd4, 13'h07FF, 13'h1FFF},   // R5
      {3'd1, 13'h0000, 13'h0000},   // R2 wrap
      {3'd6, 13'h0007, 13'h0000},   // R7
      {3'd4, 13'h0400, 13'h0400},   // R5
      {3'd5, 13'h00FF, 13'h07FF},   // R6
      {3'd6, 13'h00E5, 13'h07FF}    // R7 only 5 bits kept
   };

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      advance = 0; irq_take = 0; ret_go = 0; jump_go = 0; rf_wr_en = 0;
      rf_addr = 7'h7F; jump_tgt = '0; stack_addr = '0; rf_wdata = '0;
   endtask

   task automatic apply_op(input logic [2:0] op, input logic [12:0] d);
      idle_inputs();
      case (op)
         3'd1: advance = 1;
         3'd2: irq_take = 1;
         3'd3: begin ret_go = 1; stack_addr = d; end
         3'd4: begin jump_go = 1; jump_tgt = d[10:0]; end
         3'd5: begin rf_wr_en = 1; rf_addr = 7'h02; rf_wdata = d[7:0]; end
         3'd6: begin rf_wr_en = 1; rf_addr = 7'h0A; rf_wdata = d[7:0]; end
         3'd7: begin rf_wr_en = 1; rf_addr = 7'h13; rf_wdata = d[7:0]; end
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic read_reg(input logic [6:0] a, output logic [7:0] v);
      rf_addr = a;
      #1;
      v = rf_rdata;
      rf_addr = 7'h7F;
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      idle_inputs();
      repeat (2) @(negedge clk);
      check("R1 reset", fetch_addr, 13'h0000);
      rst_n = 1;
      @(negedge clk);
      read_reg(7'h0A, rv);
      check("R1 latch after reset", {5'd0, rv}, 13'h0000);

      for (int i = 0; i < NV; i++) begin
         apply_op(VEC[i][28:26], VEC[i][25:13]);
         check("table step", fetch_addr, VEC[i][12:0]);
      end

      read_reg(7'h0A, rv);
      check("R7 latch readback", {5'd0, rv}, 13'h0005);
      read_reg(7'h02, rv);
      check("R8 low byte read", {5'd0, rv}, 13'h00FF);
      check("R10 push", push_addr, 13'h0800);

      // R11: everything at once -> interrupt
      idle_inputs();
      irq_take = 1; ret_go = 1; jump_go = 1; advance = 1; stack_addr = 13'h1111;
      @(posedge clk); @(negedge clk); idle_inputs();
      check("R11 irq first", fetch_addr, 13'h0004);

      ret_go = 1; jump_go = 1; stack_addr = 13'h1234; jump_tgt = 11'h055;
      @(posedge clk); @(negedge clk); idle_inputs();
      check("R11 ret over jump", fetch_addr, 13'h1234);

      read_reg(7'h0A, rv);
      check("R9 latch kept after return", {5'd0, rv}, 13'h0005);

      jump_go = 1; jump_tgt = 11'h066; rf_wr_en = 1; rf_addr = 7'h02; rf_wdata = 8'hAA;
      @(posedge clk); @(negedge clk); idle_inputs();
      check("R11 jump over low write", fetch_addr, 13'h0066);

      advance = 1; rf_wr_en = 1; rf_addr = 7'h02; rf_wdata = 8'h3C;
      @(posedge clk); @(negedge clk); idle_inputs();
      check("R11 low write over advance", fetch_addr, 13'h053C);

      apply_op(3'd3, 13'h1FFF);
      check("R10 push wrap", push_addr, 13'h0000);

      apply_op(3'd7, 13'h00FF);
      read_reg(7'h0A, rv);
      check("R12 latch untouched", {5'd0, rv}, 13'h0005);
      check("R12 pc untouched", fetch_addr, 13'h1FFF);

      rst_n = 0;
      #1;
      check("R1 async reset", fetch_addr, 13'h0000);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      read_reg(7'h0A, rv);
      check("R1 latch cleared", {5'd0, rv}, 13'h0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule